// File: doc/BRIEF.md
# Snapshot-Read System Timer with Alarm Comparator

This block is a free-running 52-bit up-counter with a 32-bit register port. The counter moves by one on each cycle where the tick-enable input is high. The tick-enable input stands for the nominal 16 MHz counting rate. When the freeze option is enabled in the control register, a CPU-stall input holds the count.

Software never reads the live count directly. It writes a snapshot request and waits for a valid flag. It then reads a low word and a high word that do not change under it. A new count is written into two staged words. These take effect only when software writes an apply strobe.

The alarm target is also staged and has its own apply strobe. Once applied, the comparator raises a sticky pending bit when the count is at or past the target. The interrupt output is that pending bit gated by an enable bit, and a write of 1 to the clear register removes the pending bit.

In one-shot mode the comparator disarms after it fires. In periodic mode it moves its active target forward by the staged target value after each hit.

Top module: `snap_alarm_timer`

## Requirements
- R1: On each clock with `tick_en` high, the count rises by exactly one. With `tick_en` low, the count holds. Above 2^52-1 the count wraps to 0.
- R2: When CTRL bit 1 (freeze enable) is set and `cpu_stall` is high, the count holds. When CTRL bit 1 is clear, `cpu_stall` has no effect.
- R3: Writing address 1 with bit 30 set makes bit 29 of address 1 read 0 after that clock edge. One edge later, bit 29 reads 1. At that point the snapshot words hold the count as it stood one edge after the request was written.
- R4: Address 2 (count bits 31:0) and address 3 (count bits 51:32, upper bits zero) stay unchanged until the next snapshot request.
- R5: Address 4 (low word) and address 5 (high word, only bits 19:0 kept) stage a new count and do not disturb the counter. Writing address 6 with bit 0 set loads the staged value at that edge, and the count does not advance in that cycle.
- R6: Address 7 (low word) and address 8 (high word, 20 bits) stage the alarm target. Writing address 9 with bit 0 set copies the staged target into the comparator and arms it. Until then, the staged value has no effect.
- R7: With CTRL bit 2 clear (one-shot), the armed comparator sets the pending bit once when count >= target. After the pending bit is cleared, it does not set again until the next apply.
- R8: A target that the count has already passed when it is applied still sets the pending bit.
- R9: With CTRL bit 0 (comparator work enable) clear, the pending bit never sets.
- R10: The pending bit reads as bit 0 of address 11. It is sticky until a write of 1 to bit 0 of address 12, and a write of 0 there does nothing. `irq` is high exactly when the pending bit and bit 0 of address 10 (interrupt enable) are both 1.
- R11: With CTRL bit 2 set (periodic), each hit adds the staged target value to the active target, so the alarm fires again one period later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count-advance enable, one pulse per timer tick |
| cpu_stall | input | 1 | CPU halted; freezes the count when freeze is enabled |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register word address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data (combinational on addr) |
| irq | output | 1 | Level alarm interrupt |

## Verification
The bench goes after the snapshot handshake. A design that set the valid flag at the request edge, or let the value words track the live count, would return torn or stale words. It loads a count just below 2^52 and ticks through the wrap: a carry lost between the two words would show as a wrong high word.

It arms a target the count has already passed, and a design with an equality comparator would never interrupt. It clears a one-shot alarm while the count is still past the target, and a design that does not disarm would set the pending bit again. It also checks that a staged value changes nothing before its apply strobe, and that a disabled comparator stays silent.

// File: rtl/sat_pkg.sv
package sat_pkg;
   // Register word offsets
   localparam int unsigned OFS_CTRL    = 0;
   localparam int unsigned OFS_OP      = 1;
   localparam int unsigned OFS_SNAP_LO = 2;
   localparam int unsigned OFS_SNAP_HI = 3;
   localparam int unsigned OFS_LD_LO   = 4;
   localparam int unsigned OFS_LD_HI   = 5;
   localparam int unsigned OFS_LD_GO   = 6;
   localparam int unsigned OFS_TG_LO   = 7;
   localparam int unsigned OFS_TG_HI   = 8;
   localparam int unsigned OFS_TG_GO   = 9;
   localparam int unsigned OFS_IRQ_EN  = 10;
   localparam int unsigned OFS_IRQ_ST  = 11;
   localparam int unsigned OFS_IRQ_CLR = 12;
   localparam int unsigned NUM_REGS    = 13;

   // Bit positions
   localparam int unsigned BIT_WORK    = 0;
   localparam int unsigned BIT_FREEZE  = 1;
   localparam int unsigned BIT_PERIOD  = 2;
   localparam int unsigned BIT_SNAPREQ = 30;
   localparam int unsigned BIT_SNAPVLD = 29;

   typedef struct packed {
      logic period_en;
      logic freeze_en;
      logic work_en;
   } ctrl_t;
endpackage

// File: rtl/sat_regs.sv
module sat_regs
   import sat_pkg::*;
#(
   parameter int unsigned CNT_W  = 52,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [CNT_W-1:0]  snap_val,
   input  logic              snap_valid,
   input  logic              irq_raw,
   output ctrl_t             ctrl,
   output logic [CNT_W-1:0]  ld_val,
   output logic [CNT_W-1:0]  tg_val,
   output logic              irq_en,
   output logic              snap_req,
   output logic              ld_go,
   output logic              tg_go,
   output logic              irq_clr
);
   localparam int unsigned HI_W  = CNT_W - DATA_W;
   localparam int unsigned PAD_W = DATA_W - HI_W;

   generate
      if (ADDR_W < 4) begin : g_bad_addr
         $error("ADDR_W too small for the register map");
      end
      if (BIT_SNAPREQ >= DATA_W) begin : g_bad_bit
         $error("snapshot request bit outside the data word");
      end
   endgenerate

   logic [DATA_W-1:0] ld_lo_q, tg_lo_q;
   logic [HI_W-1:0]   ld_hi_q, tg_hi_q;

   function automatic logic hit_addr(input logic [ADDR_W-1:0] a, input int unsigned ofs);
      return a == ADDR_W'(ofs);
   endfunction

   always_comb begin
      snap_req = wr_en && hit_addr(addr, OFS_OP) && wdata[BIT_SNAPREQ];
      ld_go    = wr_en && hit_addr(addr, OFS_LD_GO) && wdata[0];
      tg_go    = wr_en && hit_addr(addr, OFS_TG_GO) && wdata[0];
      irq_clr  = wr_en && hit_addr(addr, OFS_IRQ_CLR) && wdata[0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl    <= '0;
         ld_lo_q <= '0;
         ld_hi_q <= '0;
         tg_lo_q <= '0;
         tg_hi_q <= '0;
         irq_en  <= 1'b0;
      end else if (wr_en) begin
         if (hit_addr(addr, OFS_CTRL)) begin
            ctrl.work_en   <= wdata[BIT_WORK];
            ctrl.freeze_en <= wdata[BIT_FREEZE];
            ctrl.period_en <= wdata[BIT_PERIOD];
         end
         if (hit_addr(addr, OFS_LD_LO))  ld_lo_q <= wdata;
         if (hit_addr(addr, OFS_LD_HI))  ld_hi_q <= wdata[HI_W-1:0];
         if (hit_addr(addr, OFS_TG_LO))  tg_lo_q <= wdata;
         if (hit_addr(addr, OFS_TG_HI))  tg_hi_q <= wdata[HI_W-1:0];
         if (hit_addr(addr, OFS_IRQ_EN)) irq_en  <= wdata[0];
      end
   end

   assign ld_val = {ld_hi_q, ld_lo_q};
   assign tg_val = {tg_hi_q, tg_lo_q};

   always_comb begin
      rdata = '0;
      if (hit_addr(addr, OFS_CTRL)) begin
         rdata[BIT_WORK]   = ctrl.work_en;
         rdata[BIT_FREEZE] = ctrl.freeze_en;
         rdata[BIT_PERIOD] = ctrl.period_en;
      end
      if (hit_addr(addr, OFS_OP))      rdata[BIT_SNAPVLD] = snap_valid;
      if (hit_addr(addr, OFS_SNAP_LO)) rdata = snap_val[DATA_W-1:0];
      if (hit_addr(addr, OFS_SNAP_HI)) rdata = {{PAD_W{1'b0}}, snap_val[CNT_W-1:DATA_W]};
      if (hit_addr(addr, OFS_LD_LO))   rdata = ld_lo_q;
      if (hit_addr(addr, OFS_LD_HI))   rdata = {{PAD_W{1'b0}}, ld_hi_q};
      if (hit_addr(addr, OFS_TG_LO))   rdata = tg_lo_q;
      if (hit_addr(addr, OFS_TG_HI))   rdata = {{PAD_W{1'b0}}, tg_hi_q};
      if (hit_addr(addr, OFS_IRQ_EN))  rdata[0] = irq_en;
      if (hit_addr(addr, OFS_IRQ_ST))  rdata[0] = irq_raw;
   end

   AST_HI_TRIM: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && hit_addr(addr, OFS_LD_HI)) |=> (ld_val[CNT_W-1:DATA_W] == $past(wdata[HI_W-1:0]))); // R5
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
   parameter int unsigned CNT_W     = 52,
   parameter bit          HAS_STALL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             cpu_stall,
   input  logic             freeze_en,
   input  logic             ld_go,
   input  logic [CNT_W-1:0] ld_val,
   input  logic             snap_req,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] snap_val,
   output logic             snap_valid
);
   logic frozen;
   logic snap_pend;

   generate
      if (HAS_STALL) begin : g_stall
         assign frozen = freeze_en & cpu_stall;
      end else begin : g_nostall
         assign frozen = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  count <= '0;
      else if (ld_go)              count <= ld_val;
      else if (tick_en && !frozen) count <= count + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_pend  <= 1'b0;
         snap_valid <= 1'b0;
         snap_val   <= '0;
      end else if (snap_req) begin
         snap_pend  <= 1'b1;
         snap_valid <= 1'b0;
      end else if (snap_pend) begin
         snap_pend  <= 1'b0;
         snap_valid <= 1'b1;
         snap_val   <= count;
      end
   end

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && !ld_go && !(freeze_en && cpu_stall)) |=> (count == $past(count) + 1'b1)); // R1
   AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !ld_go) |=> $stable(count)); // R1
   AST_CNT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_STALL && freeze_en && cpu_stall && !ld_go) |=> $stable(count)); // R2
   AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      ld_go |=> (count == $past(ld_val))); // R5
   AST_SNAP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      snap_req |=> !snap_valid); // R3
   AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (snap_valid && !snap_req) |=> $stable(snap_val)); // R4
endmodule

// File: rtl/sat_alarm.sv
module sat_alarm #(
   parameter int unsigned CNT_W = 52
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] tg_val,
   input  logic             tg_go,
   input  logic             work_en,
   input  logic             period_en,
   input  logic             irq_en,
   input  logic             irq_clr,
   output logic             irq_raw,
   output logic             irq
);
   logic [CNT_W-1:0] act_tg;
   logic             armed;
   logic             hit;

   assign hit = work_en && armed && (count >= act_tg);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_tg <= '0;
         armed  <= 1'b0;
      end else if (tg_go) begin
         act_tg <= tg_val;
         armed  <= 1'b1;
      end else if (hit) begin
         if (period_en) act_tg <= act_tg + tg_val;
         else           armed  <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_raw <= 1'b0;
      else        irq_raw <= hit | (irq_raw & ~irq_clr);
   end

   assign irq = irq_raw & irq_en;

   AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !period_en && !tg_go) |=> !armed); // R7
   AST_NO_WORK: assert property (@(posedge clk) disable iff (!rst_n)
      (!work_en && !irq_raw) |=> !irq_raw); // R9
   AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_raw && !irq_clr) |=> irq_raw); // R10
   AST_PERIOD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && period_en && !tg_go) |=> (act_tg == $past(act_tg) + $past(tg_val))); // R11
endmodule

// File: rtl/snap_alarm_timer.sv
module snap_alarm_timer
   import sat_pkg::*;
#(
   parameter int unsigned CNT_W     = 52,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 4,
   parameter bit          HAS_STALL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              cpu_stall,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq
);
   generate
      if (CNT_W <= DATA_W || CNT_W >= 2 * DATA_W) begin : g_bad_width
         $error("CNT_W must lie strictly between DATA_W and 2*DATA_W");
      end
   endgenerate

   ctrl_t            ctrl;
   logic [CNT_W-1:0] count, snap_val, ld_val, tg_val;
   logic             snap_valid, irq_raw, irq_en;
   logic             snap_req, ld_go, tg_go, irq_clr;

   sat_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .snap_val(snap_val), .snap_valid(snap_valid),
      .irq_raw(irq_raw), .ctrl(ctrl), .ld_val(ld_val), .tg_val(tg_val),
      .irq_en(irq_en), .snap_req(snap_req), .ld_go(ld_go), .tg_go(tg_go),
      .irq_clr(irq_clr)
   );

   sat_counter #(.CNT_W(CNT_W), .HAS_STALL(HAS_STALL)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cpu_stall(cpu_stall),
      .freeze_en(ctrl.freeze_en), .ld_go(ld_go), .ld_val(ld_val),
      .snap_req(snap_req), .count(count), .snap_val(snap_val),
      .snap_valid(snap_valid)
   );

   sat_alarm #(.CNT_W(CNT_W)) u_alarm (
      .clk(clk), .rst_n(rst_n), .count(count), .tg_val(tg_val), .tg_go(tg_go),
      .work_en(ctrl.work_en), .period_en(ctrl.period_en), .irq_en(irq_en),
      .irq_clr(irq_clr), .irq_raw(irq_raw), .irq(irq)
   );

   AST_SNAP_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(snap_valid) |-> $past(snap_req, 2)); // R3
endmodule

// File: tb/snap_alarm_timer_tb.sv
module snap_alarm_timer_tb;
   localparam logic [3:0] A_CTRL = 0, A_OP = 1, A_VLO = 2, A_VHI = 3,
      A_LLO = 4, A_LHI = 5, A_LGO = 6, A_TLO = 7, A_THI = 8, A_TGO = 9,
      A_IEN = 10, A_IST = 11, A_ICLR = 12;

   logic        clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, cpu_stall = 1'b0, wr_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   wire  [31:0] rdata;
   wire         irq;

   snap_alarm_timer u_dut (.clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .cpu_stall(cpu_stall), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .irq(irq));

   always #10 clk = ~clk;

   int    n_cmp = 0, n_bad = 0;
   string tag = "R1";

   // behavioural reference
   localparam logic [63:0] MASK = (64'd1 << 52) - 1;
   logic [63:0] m_cnt = 0, m_snap = 0, m_ld = 0, m_tg = 0, m_act = 0;
   bit m_pend = 0, m_vld = 0, m_work = 0, m_frz = 0, m_per = 0, m_ien = 0, m_raw = 0, m_arm = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_snap = 0; m_ld = 0; m_tg = 0; m_act = 0;
         m_pend = 0; m_vld = 0; m_work = 0; m_frz = 0; m_per = 0;
         m_ien = 0; m_raw = 0; m_arm = 0;
      end else begin
         bit fire;
         logic [63:0] old_cnt;
         old_cnt = m_cnt;
         fire = m_work && m_arm && (m_cnt >= m_act);
         if (wr_en && addr == A_LGO && wdata[0]) m_cnt = m_ld;
         else if (tick_en && !(m_frz && cpu_stall)) m_cnt = (m_cnt + 1) & MASK;
         if (wr_en && addr == A_OP && wdata[30]) begin m_pend = 1; m_vld = 0; end
         else if (m_pend) begin m_pend = 0; m_vld = 1; m_snap = old_cnt; end
         m_raw = fire || (m_raw && !(wr_en && addr == A_ICLR && wdata[0]));
         if (wr_en && addr == A_TGO && wdata[0]) begin m_act = m_tg; m_arm = 1; end
         else if (fire) begin
            if (m_per) m_act = (m_act + m_tg) & MASK;
            else m_arm = 0;
         end
         if (wr_en) case (addr)
            A_CTRL: begin m_work = wdata[0]; m_frz = wdata[1]; m_per = wdata[2]; end
            A_LLO:  m_ld = {m_ld[63:32], wdata};
            A_LHI:  m_ld = {32'd0, 12'd0, wdata[19:0], m_ld[31:0]};
            A_TLO:  m_tg = {m_tg[63:32], wdata};
            A_THI:  m_tg = {32'd0, 12'd0, wdata[19:0], m_tg[31:0]};
            A_IEN:  m_ien = wdata[0];
            default: ;
         endcase
      end
   end

   function automatic logic [31:0] m_read(input logic [3:0] a);
      case (a)
         A_CTRL: return {29'd0, m_per, m_frz, m_work};
         A_OP:   return {2'b0, m_vld, 29'd0};
         A_VLO:  return m_snap[31:0];
         A_VHI:  return m_snap[63:32];
         A_LLO:  return m_ld[31:0];
         A_LHI:  return m_ld[63:32];
         A_TLO:  return m_tg[31:0];
         A_THI:  return m_tg[63:32];
         A_IEN:  return {31'd0, m_ien};
         A_IST:  return {31'd0, m_raw};
         default: return 32'd0;
      endcase
   endfunction

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic step(input logic w, input logic [3:0] a, input logic [31:0] d);
      wr_en = w; addr = a; wdata = d;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
      check({31'd0, irq}, {31'd0, m_raw & m_ien}, "irq vs model (R10)");
      check(rdata, m_read(addr), "rdata vs model");
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d); step(1'b1, a, d); endtask
   task automatic rd(input logic [3:0] a); step(1'b0, a, 32'd0); endtask
   task automatic idle(input int n); for (int i = 0; i < n; i++) rd(A_IST); endtask
   task automatic snap();
      wr(A_OP, 32'h4000_0000);
      check(rdata & 32'h2000_0000, 32'd0, "valid drops after request (R3)");
      rd(A_OP);
      check(rdata & 32'h2000_0000, 32'h2000_0000, "valid set one edge later (R3)");
      rd(A_VLO); rd(A_VHI);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      tag = "watchdog";
      n_bad++;
      $display("FAIL %s: run did not finish, actual hung expected done", tag);
      summary();
      $finish;
   end

   initial begin
      tag = "R4";
      idle(3);
      rst_n = 1'b1;
      for (int a = 0; a < 13; a++) rd(4'(a));
      check(rdata, 32'd0, "reset readback zero (R4)");

      tag = "R1";
      tick_en = 1'b1; idle(20); snap();
      for (int i = 0; i < 12; i++) begin tick_en = i[0]; rd(A_OP); end
      tick_en = 1'b0; snap(); idle(3); rd(A_VLO);

      tag = "R2";
      wr(A_CTRL, 32'h2);
      tick_en = 1'b1; cpu_stall = 1'b1; idle(10); snap();
      wr(A_CTRL, 32'h0); idle(10); snap();
      cpu_stall = 1'b0; tick_en = 1'b0;

      tag = "R5";
      wr(A_LLO, 32'hFFFF_FFF0); wr(A_LHI, 32'hFFFF_FFFF);
      rd(A_LHI); check(rdata, 32'h000F_FFFF, "load high keeps 20 bits (R5)");
      snap(); wr(A_LGO, 32'h1); snap();
      rd(A_VLO); check(rdata, 32'hFFFF_FFF0, "loaded low word (R5)");
      rd(A_VHI); check(rdata, 32'h000F_FFFF, "loaded high word (R5)");
      tag = "R1";
      tick_en = 1'b1; idle(20); tick_en = 1'b0; snap();
      rd(A_VHI); check(rdata, 32'd0, "high word after wrap (R1)");

      tag = "R6";
      wr(A_LLO, 32'd0); wr(A_LHI, 32'd0); wr(A_LGO, 32'h1);
      wr(A_TLO, 32'd40); wr(A_IEN, 32'h1); wr(A_CTRL, 32'h1);
      tick_en = 1'b1; idle(60);
      rd(A_IST); check(rdata, 32'd0, "staged target inert before apply (R6)");

      tag = "R8";
      wr(A_TGO, 32'h1); idle(2);
      rd(A_IST); check(rdata, 32'd1, "passed target still fires (R8)");

      tag = "R7";
      wr(A_ICLR, 32'h1); idle(10);
      rd(A_IST); check(rdata, 32'd0, "one-shot does not refire (R7)");
      wr(A_LLO, 32'd0); wr(A_LGO, 32'h1); wr(A_TLO, 32'd25); wr(A_TGO, 32'h1);
      idle(40); wr(A_ICLR, 32'h1); idle(5);

      tag = "R9";
      wr(A_CTRL, 32'h0); wr(A_TGO, 32'h1); idle(10);
      rd(A_IST); check(rdata, 32'd0, "no hit with work enable clear (R9)");

      tag = "R10";
      wr(A_CTRL, 32'h1); wr(A_IEN, 32'h0); idle(3);
      check({31'd0, irq}, 32'd0, "irq masked while enable clear (R10)");
      wr(A_IEN, 32'h1); check({31'd0, irq}, 32'd1, "irq follows enable (R10)");
      wr(A_ICLR, 32'h0); rd(A_IST); check(rdata, 32'd1, "clear with 0 ignored (R10)");
      wr(A_ICLR, 32'h1); rd(A_IST); check(rdata, 32'd0, "clear with 1 drops status (R10)");

      tag = "R11";
      wr(A_CTRL, 32'h5); wr(A_LLO, 32'd0); wr(A_LGO, 32'h1);
      wr(A_TLO, 32'd15); wr(A_TGO, 32'h1);
      for (int k = 0; k < 4; k++) begin idle(14); wr(A_ICLR, 32'h1); end
      idle(20);
      tick_en = 1'b0; idle(2);

      summary();
      $finish;
   end
endmodule